// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks the error-correction code read back from flash against the code that was worked out again over the same data. It then says what kind of error, if any, is present. Each code word covers one 256-byte sector. A word is 24 bits wide and is assembled from three bytes, least significant byte first. Inside the word, bits 10:0 hold one 11-bit half and bits 21:11 hold the complementary half.

The block XORs the two words to form a syndrome and sorts it into one of four classes:
- clean;
- damage confined to the check bytes;
- a correctable single-bit data error;
- an uncorrectable pattern.

For a correctable error it reports the failing byte index and bit index, so that software can flip that bit in its buffer.

Two identical classifier lanes sit side by side. Lane 0 handles the first 256 bytes. When wide mode is set, lane 1 handles the second 256 bytes of a 512-byte sector. The error flags of the two lanes are ORed into one sector-level error flag.

A small controller has two states:
- **IDLE**: waiting; no result is being reported.
- **REPORT**: the cycle in which fresh results are presented.

It makes three transitions:
- IDLE→REPORT on a start strobe.
- REPORT→REPORT on a start strobe that arrives during the report cycle.
- REPORT→IDLE when no start strobe arrives.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `start` high. All result outputs hold their values until the next start.
- R2: Lane 0 uses bits 23:0 of each 48-bit input and lane 1 uses bits 47:24. Within a lane word, bits 10:0 are the low half and bits 21:11 are the high half. The syndrome covers all 24 bits.
- R3: A zero syndrome yields status 0 (clean).
- R4: If either the computed word or the stored word of a lane is all zero, that lane reports status 0, whatever the syndrome.
- R5: A syndrome with exactly one bit set yields status 1 (check-byte error), with byte and bit indices 0.
- R6: A syndrome with exactly 11 bits set, where (calc_low ^ calc_high) ^ (stored_low ^ stored_high) equals 0x7FF, yields status 2 (correctable).
- R7: For status 2, the byte index is bits 10:3 and the bit index is bits 2:0 of calc[10:0] ^ stored[10:0]. For any other status both indices are 0.
- R8: Every other non-zero syndrome yields status 3 (uncorrectable).
- R9: With `wide_mode` low, bits 47:24 of both inputs are ignored: lane 1 reports status 0 with indices 0.
- R10: `sector_bad` is high when any active lane reports status 1 or status 3.
- R11: A start in the report cycle loads new results, and `done` stays high for one more cycle.
- R12: After reset, `done`, `sector_bad`, both statuses and all indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample inputs and classify |
| wide_mode | input | 1 | 1 = 512-byte sector (both lanes active) |
| calc_code | input | 48 | Recomputed code words, lane 1 in bits 47:24 |
| stored_code | input | 48 | Stored code words, lane 1 in bits 47:24 |
| done | output | 1 | Result-valid pulse |
| lane0_status | output | 2 | Lane 0 class: 0 clean, 1 check bytes, 2 correctable, 3 uncorrectable |
| lane0_byte | output | 8 | Lane 0 failing byte index |
| lane0_bit | output | 3 | Lane 0 failing bit index |
| lane1_status | output | 2 | Lane 1 class, same encoding |
| lane1_byte | output | 8 | Lane 1 failing byte index |
| lane1_bit | output | 3 | Lane 1 failing bit index |
| sector_bad | output | 1 | OR of lane error flags |

## Verification
Two functions can fall in the same cycle: presenting one result and accepting the next start. The bench provokes this by raising `start` again in the `done` cycle. It checks that the first set of results is visible in that cycle, and that the second set of results, with `done` still high, appears in the following cycle. The bench also makes both lanes fail at once in wide mode, and checks that the combined flag and each lane's own status are judged independently.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
    localparam int HALF_W     = 11;
    localparam int WORD_W     = 24;
    localparam int BIT_IDX_W  = 3;
    localparam int BYTE_IDX_W = HALF_W - BIT_IDX_W;
    localparam int CNT_W      = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        ECC_CLEAN     = 2'd0,
        ECC_CHECK_BAD = 2'd1,
        ECC_FIXABLE   = 2'd2,
        ECC_FATAL     = 2'd3
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e             status;
        logic [BYTE_IDX_W-1:0]   byte_idx;
        logic [BIT_IDX_W-1:0]    bit_idx;
    } lane_result_t;

    typedef enum logic {
        CTL_IDLE   = 1'b0,
        CTL_REPORT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W   = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ecc_lane_classify.sv
module ecc_lane_classify
    import ecc_corr_pkg::*;
(
    input  logic              enable,
    input  logic [WORD_W-1:0] calc_word,
    input  logic [WORD_W-1:0] stored_word,
    output lane_result_t      result
);
    logic [WORD_W-1:0] synd;
    logic [CNT_W-1:0]  ones;
    logic [HALF_W-1:0] calc_fold;
    logic [HALF_W-1:0] stored_fold;
    logic [HALF_W-1:0] low_synd;
    logic              exempt;

    assign synd        = calc_word ^ stored_word;
    assign calc_fold   = calc_word[HALF_W-1:0] ^ calc_word[2*HALF_W-1:HALF_W];
    assign stored_fold = stored_word[HALF_W-1:0] ^ stored_word[2*HALF_W-1:HALF_W];
    assign low_synd    = synd[HALF_W-1:0];
    assign exempt      = !enable || (synd == '0) || (calc_word == '0) || (stored_word == '0);

    ecc_popcount #(.W(WORD_W)) u_pop (
        .vec   (synd),
        .count (ones)
    );

    always_comb begin
        result = '0;
        if (exempt) begin
            result.status = ECC_CLEAN;
        end else if (ones == CNT_W'(1)) begin
            result.status = ECC_CHECK_BAD;
        end else if ((ones == CNT_W'(HALF_W)) && ((calc_fold ^ stored_fold) == '1)) begin
            result.status   = ECC_FIXABLE;
            result.byte_idx = low_synd[HALF_W-1:BIT_IDX_W];
            result.bit_idx  = low_synd[BIT_IDX_W-1:0];
        end else begin
            result.status = ECC_FATAL;
        end
    end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
    import ecc_corr_pkg::*;
#(
    parameter int LANES = 2,
    localparam int IN_W = LANES * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  wide_mode,
    input  logic [IN_W-1:0]       calc_code,
    input  logic [IN_W-1:0]       stored_code,
    output logic                  done,
    output logic [1:0]            lane0_status,
    output logic [BYTE_IDX_W-1:0] lane0_byte,
    output logic [BIT_IDX_W-1:0]  lane0_bit,
    output logic [1:0]            lane1_status,
    output logic [BYTE_IDX_W-1:0] lane1_byte,
    output logic [BIT_IDX_W-1:0]  lane1_bit,
    output logic                  sector_bad
);
    ctl_state_e   state_q, state_d;
    lane_result_t res_now [LANES];
    lane_result_t res_q   [LANES];
    logic [LANES-1:0] lane_err;
    logic             bad_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ecc_lane_classify u_cls (
            .enable      ((g == 0) || wide_mode),
            .calc_word   (calc_code[g*WORD_W +: WORD_W]),
            .stored_word (stored_code[g*WORD_W +: WORD_W]),
            .result      (res_now[g])
        );
        assign lane_err[g] = (res_now[g].status == ECC_CHECK_BAD) ||
                             (res_now[g].status == ECC_FATAL);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:   state_d = start ? CTL_REPORT : CTL_IDLE;
            CTL_REPORT: state_d = start ? CTL_REPORT : CTL_IDLE;
            default:    state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) res_q[i] <= '0;
            bad_q <= 1'b0;
        end else if (start) begin
            for (int i = 0; i < LANES; i++) res_q[i] <= res_now[i];
            bad_q <= |lane_err;
        end
    end

    assign done         = (state_q == CTL_REPORT);
    assign lane0_status = res_q[0].status;
    assign lane0_byte   = res_q[0].byte_idx;
    assign lane0_bit    = res_q[0].bit_idx;
    assign lane1_status = res_q[1].status;
    assign lane1_byte   = res_q[1].byte_idx;
    assign lane1_bit    = res_q[1].bit_idx;
    assign sector_bad   = bad_q;

    // R1
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R1
    done_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R1
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(lane0_status) && $stable(lane0_byte) && $stable(lane1_status) && $stable(sector_bad)));
    // R9
    narrow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wide_mode) |=> (lane1_status == 2'd0 && lane1_byte == '0 && lane1_bit == '0));
    // R7
    index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane0_status != 2'd2) |-> (lane0_byte == '0 && lane0_bit == '0));
    // R10
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_bad == (lane0_status == 2'd1 || lane0_status == 2'd3 ||
                       lane1_status == 2'd1 || lane1_status == 2'd3));
endmodule

// File: tb/ecc_syndrome_corrector_tb.sv
`timescale 1ns/1ps
module ecc_syndrome_corrector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [47:0] calc_code = '0;
    logic [47:0] stored_code = '0;
    logic        done, sector_bad;
    logic [1:0]  lane0_status, lane1_status;
    logic [7:0]  lane0_byte, lane1_byte;
    logic [2:0]  lane0_bit, lane1_bit;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ecc_syndrome_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .calc_code(calc_code), .stored_code(stored_code), .done(done),
        .lane0_status(lane0_status), .lane0_byte(lane0_byte), .lane0_bit(lane0_bit),
        .lane1_status(lane1_status), .lane1_byte(lane1_byte), .lane1_bit(lane1_bit),
        .sector_bad(sector_bad)
    );

    // returns {status[1:0], byte[7:0], bit[2:0]}
    function automatic logic [12:0] model(input logic [23:0] c, input logic [23:0] s, input logic en);
        logic [23:0] syn;
        logic [10:0] lo;
        syn = c ^ s;
        lo  = syn[10:0];
        if (!en || syn == 0 || c == 0 || s == 0) return 13'd0;
        if ($countones(syn) == 1) return {2'd1, 11'd0};
        if ($countones(syn) == 11 &&
            ((c[10:0] ^ c[21:11]) ^ (s[10:0] ^ s[21:11])) == 11'h7FF)
            return {2'd2, lo[10:3], lo[2:0]};
        return {2'd3, 11'd0};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic compare(input logic [47:0] c, input logic [47:0] s, input logic w, input string req);
        logic [12:0] e0, e1;
        logic        bad;
        e0  = model(c[23:0], s[23:0], 1'b1);
        e1  = model(c[47:24], s[47:24], w);
        bad = (e0[12:11] == 2'd1) || (e0[12:11] == 2'd3) || (e1[12:11] == 2'd1) || (e1[12:11] == 2'd3);
        chk(req, "lane0 status", lane0_status, e0[12:11]);
        chk(req, "lane0 byte",   lane0_byte,   e0[10:3]);
        chk(req, "lane0 bit",    lane0_bit,    e0[2:0]);
        chk(req, "lane1 status", lane1_status, e1[12:11]);
        chk(req, "lane1 byte",   lane1_byte,   e1[10:3]);
        chk(req, "lane1 bit",    lane1_bit,    e1[2:0]);
        chk(req, "sector_bad",   sector_bad,   bad);
    endtask

    task automatic run(input logic [47:0] c, input logic [47:0] s, input logic w, input string req);
        @(negedge clk);
        calc_code = c; stored_code = s; wide_mode = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", "done after start", done, 1);
        compare(c, s, w, req);
    endtask

    function automatic logic [23:0] fixable(input logic [23:0] s, input logic [10:0] e);
        return {2'b00, s[21:11] ^ ~e, s[10:0] ^ e};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [23:0] a, b;
        logic [47:0] c1, s1;
        int          seed_ret;
        seed_ret = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "done", done, 0);
        chk("R12", "lane0 status", lane0_status, 0);
        chk("R12", "lane1 status", lane1_status, 0);
        chk("R12", "sector_bad", sector_bad, 0);
        rst_n = 1'b1;

        a = 24'h3A5C17;
        run({a, a}, {a, a}, 1'b1, "R3");
        run({24'h0, 24'h0}, {24'h123456, 24'h00F0F0}, 1'b1, "R4");
        run({24'h1, 24'h777777}, {24'h0, 24'h000000}, 1'b1, "R4");
        run({24'h0, a ^ 24'h400000}, {24'h0, a}, 1'b0, "R5");
        chk("R5", "bit22 check-byte status", lane0_status, 1);
        b = 24'h1F00AA;
        run({24'h0, fixable(b, 11'h7FF)}, {24'h0, b}, 1'b0, "R6");
        chk("R7", "max byte index", lane0_byte, 255);
        chk("R7", "max bit index", lane0_bit, 7);
        run({24'h0, fixable(b, 11'h235)}, {24'h0, b}, 1'b0, "R7");
        chk("R7", "byte index", lane0_byte, 11'h235 >> 3);
        run({24'h0, b ^ 24'h000011}, {24'h0, b}, 1'b0, "R8");
        chk("R8", "two-bit status", lane0_status, 3);
        run({24'hABCDEF, a}, {24'h001234, a}, 1'b0, "R9");
        chk("R9", "narrow lane1 status", lane1_status, 0);
        run({b ^ 24'h000101, a ^ 24'h000001}, {b, a}, 1'b1, "R10");
        chk("R10", "both lanes bad", sector_bad, 1);
        chk("R2", "lane1 fatal", lane1_status, 3);
        run({fixable(b, 11'h0F3), a}, {b, a}, 1'b1, "R2");
        chk("R2", "lane1 fixable", lane1_status, 2);

        // R1 hold: inputs change without start
        @(negedge clk);
        calc_code = '1; stored_code = 48'h1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "done low without start", done, 0);
        compare({fixable(b, 11'h0F3), a}, {b, a}, 1'b1, "R1");

        // R11 back-to-back
        c1 = {24'h0, a ^ 24'h000002}; s1 = {24'h0, a};
        @(negedge clk);
        calc_code = c1; stored_code = s1; wide_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        chk("R11", "first done", done, 1);
        compare(c1, s1, 1'b0, "R11");
        calc_code = {24'h0, fixable(b, 11'h4C1)}; stored_code = {24'h0, b}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "second done", done, 1);
        compare({24'h0, fixable(b, 11'h4C1)}, {24'h0, b}, 1'b0, "R11");
        @(negedge clk);
        chk("R11", "done drops", done, 0);

        for (int i = 0; i < 400; i++) begin
            logic [23:0] s0, s1w, c0, c1w;
            int kind;
            kind = $urandom_range(0, 4);
            s0  = $urandom;
            s1w = $urandom;
            case (kind)
                0: begin c0 = $urandom; c1w = $urandom; end
                1: begin c0 = fixable({2'b0, s0[21:0]}, 11'($urandom)); s0[23:22] = 2'b0;
                         c1w = fixable({2'b0, s1w[21:0]}, 11'($urandom)); s1w[23:22] = 2'b0; end
                2: begin c0 = s0 ^ (24'h1 << $urandom_range(0, 23)); c1w = s1w ^ (24'h1 << $urandom_range(0, 23)); end
                3: begin c0 = s0; c1w = s1w ^ 24'h000C00; end
                default: begin c0 = 24'h0; c1w = s1w ^ 24'h5; end
            endcase
            run({c1w, c0}, {s1w, s0}, 1'($urandom), "R6");
        end
        report();
    end
endmodule